// File: doc/BRIEF.md
# Sequenced Dual Mode-Register Port

This unit sits on the processor side of one serial channel and holds the channel's two 8-bit mode registers. Both registers answer at the same bus address. A small two-state access sequencer decides which of them a read or write reaches. After reset it selects the first register. The first access of any kind advances it to the second register, where it then stays. A pointer-reset strobe from the channel's command decoder sends it back to the first register.

The stored bits are decoded into configuration outputs for the rest of the channel:
- receiver flow-control enable
- interrupt source select
- error reporting mode
- parity mode and parity type
- multidrop flag and address/data bit polarity
- data-bit count
- channel operating mode

The sequencer has two named states. `PTR_MR1` selects mode register 1 and `PTR_MR2` selects mode register 2. It has these transitions:
- `ADVANCE`: `PTR_MR1` to `PTR_MR2` on any access without a pointer reset.
- `HOLD`: `PTR_MR2` to `PTR_MR2` on an access or an idle cycle.
- `IDLE`: `PTR_MR1` to `PTR_MR1` with no access.
- `REWIND`: either state to `PTR_MR1` on a pointer reset. This transition has priority over the others.

Top module: `mode_regs`

## Requirements
- R1: After reset, the sequencer is in `PTR_MR1` and both mode registers hold zero. All decoded outputs therefore show their zero-code values, and `data_bits` is 5.
- R2: In `PTR_MR1`, an access (`acc_en`=1, read or write) with no pointer reset moves the sequencer to `PTR_MR2` after that clock edge. A write in that cycle lands in register 1.
- R3: In `PTR_MR2`, reads and writes reach register 2 and leave the sequencer in `PTR_MR2`.
- R4: `ptr_rst`=1 returns the sequencer to `PTR_MR1` after the clock edge, from either state.
- R5: When a write and `ptr_rst` fall in the same cycle, the write lands in the register selected before that cycle, and the sequencer then goes to `PTR_MR1`.
- R6: Register 1 bit 7 drives `rx_rts_ctl`, bit 6 drives `irq_src_full`, and bit 5 drives `err_block`. Bits 4:3 drive `par_mode`, and bit 2 drives `par_type`.
- R7: Register 1 bits 1:0 give the data-bit count: codes 00, 01, 10 and 11 give 5, 6, 7 and 8 on `data_bits`.
- R8: Register 2 bits 7:6 drive `chan_mode`. The codes are 00 normal, 01 automatic echo, 10 local loopback and 11 remote loopback.
- R9: The parity mode codes are 00 with parity, 01 forced parity, 10 no parity and 11 multidrop. `multidrop_en` is 1 exactly when the code is 11. `ad_polarity` equals the parity type bit in multidrop and is 0 otherwise.
- R10: During a read (`acc_en`=1, `acc_wr`=0), `rdata` shows the currently selected register in the same cycle. At all other times `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe for the shared mode-register address |
| acc_wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| ptr_rst | input | 1 | Pointer-reset command strobe |
| rx_rts_ctl | output | 1 | Receiver flow-control enable |
| irq_src_full | output | 1 | Interrupt source: 1 = FIFO full, 0 = receiver ready |
| err_block | output | 1 | Error mode: 1 = accumulated, 0 = per character |
| par_mode | output | 2 | Parity mode code |
| par_type | output | 1 | Parity type bit |
| multidrop_en | output | 1 | Multidrop operation selected |
| ad_polarity | output | 1 | Address/data bit polarity in multidrop |
| data_bits | output | 4 | Data bits per character (5 to 8) |
| chan_mode | output | 2 | Channel operating mode |

## Verification
The bench targets the one-way pointer. A design that advanced only on writes would send the second of two reads to register 1. A design that advanced again from `PTR_MR2` would wander off the pair. The bench also aims at a write that coincides with a pointer reset: a design that let the reset act first would write register 1 when the write belonged in register 2. Random mixes of reads, writes and pointer resets are checked against a reference model, along with every parity-mode and data-length code, so that a swapped field, an off-by-one length or a multidrop flag on the wrong code shows up at the outputs.

// File: rtl/mode_regs_pkg.sv
package mode_regs_pkg;
    localparam int REG_W  = 8;
    localparam int CNT_W  = 4;
    localparam int NREGS  = 2;
    localparam int MIN_BITS = 5;

    typedef enum logic {
        PTR_MR1 = 1'b0,
        PTR_MR2 = 1'b1
    } ptr_state_e;

    typedef enum logic [1:0] {
        CM_NORMAL = 2'b00,
        CM_ECHO   = 2'b01,
        CM_LLOOP  = 2'b10,
        CM_RLOOP  = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        PM_WITH  = 2'b00,
        PM_FORCE = 2'b01,
        PM_NONE  = 2'b10,
        PM_MDROP = 2'b11
    } par_mode_e;
endpackage

// File: rtl/mode_ptr_fsm.sv
module mode_ptr_fsm
    import mode_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_en,
    input  logic ptr_rst,
    output logic sel_second
);
    ptr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_MR1;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_MR1: begin
                if (ptr_rst)     state_d = PTR_MR1;   // REWIND
                else if (acc_en) state_d = PTR_MR2;   // ADVANCE
                else             state_d = PTR_MR1;   // IDLE
            end
            PTR_MR2: begin
                if (ptr_rst)     state_d = PTR_MR1;   // REWIND
                else             state_d = PTR_MR2;   // HOLD
            end
            default:             state_d = PTR_MR1;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PTR_MR1: sel_second = 1'b0;
            PTR_MR2: sel_second = 1'b1;
            default: sel_second = 1'b0;
        endcase
    end
endmodule

// File: rtl/mode_store.sv
module mode_store
    import mode_regs_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_en,
    input  logic         acc_wr,
    input  logic         sel_second,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [W-1:0] reg1_q,
    output logic [W-1:0] reg2_q
);
    logic [W-1:0] regs_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic hit;
        assign hit = acc_en && acc_wr && (sel_second == (g == 1));
        always_ff @(posedge clk) begin
            if (!rst_n)   regs_q[g] <= '0;
            else if (hit) regs_q[g] <= wdata;
        end
    end

    assign reg1_q = regs_q[0];
    assign reg2_q = regs_q[1];

    always_comb begin
        if (acc_en && !acc_wr) rdata = sel_second ? regs_q[1] : regs_q[0];
        else                   rdata = '0;
    end
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import mode_regs_pkg::*;
(
    input  logic [REG_W-1:0] reg1,
    input  logic [REG_W-1:0] reg2,
    output logic             rx_rts_ctl,
    output logic             irq_src_full,
    output logic             err_block,
    output logic [1:0]       par_mode,
    output logic             par_type,
    output logic             multidrop_en,
    output logic             ad_polarity,
    output logic [CNT_W-1:0] data_bits,
    output logic [1:0]       chan_mode
);
    par_mode_e  pm;
    chan_mode_e cm;

    assign pm = par_mode_e'(reg1[4:3]);
    assign cm = chan_mode_e'(reg2[7:6]);

    assign rx_rts_ctl   = reg1[7];
    assign irq_src_full = reg1[6];
    assign err_block    = reg1[5];
    assign par_mode     = pm;
    assign par_type     = reg1[2];
    assign multidrop_en = (pm == PM_MDROP);
    assign ad_polarity  = (pm == PM_MDROP) ? reg1[2] : 1'b0;
    assign data_bits    = CNT_W'(MIN_BITS) + CNT_W'(reg1[1:0]);
    assign chan_mode    = cm;
endmodule

// File: rtl/mode_regs.sv
module mode_regs
    import mode_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             ptr_rst,
    output logic             rx_rts_ctl,
    output logic             irq_src_full,
    output logic             err_block,
    output logic [1:0]       par_mode,
    output logic             par_type,
    output logic             multidrop_en,
    output logic             ad_polarity,
    output logic [CNT_W-1:0] data_bits,
    output logic [1:0]       chan_mode
);
    logic             ptr_second;
    logic [REG_W-1:0] reg1_q;
    logic [REG_W-1:0] reg2_q;

    mode_ptr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .ptr_rst    (ptr_rst),
        .sel_second (ptr_second)
    );

    mode_store #(.W(REG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .sel_second (ptr_second),
        .wdata      (wdata),
        .rdata      (rdata),
        .reg1_q     (reg1_q),
        .reg2_q     (reg2_q)
    );

    mode_decode u_dec (
        .reg1         (reg1_q),
        .reg2         (reg2_q),
        .rx_rts_ctl   (rx_rts_ctl),
        .irq_src_full (irq_src_full),
        .err_block    (err_block),
        .par_mode     (par_mode),
        .par_type     (par_type),
        .multidrop_en (multidrop_en),
        .ad_polarity  (ad_polarity),
        .data_bits    (data_bits),
        .chan_mode    (chan_mode)
    );
endmodule

// File: rtl/mode_regs_chk.sv
module mode_regs_chk
    import mode_regs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en,
    input logic             acc_wr,
    input logic [REG_W-1:0] wdata,
    input logic             ptr_rst,
    input logic             ptr_second,
    input logic [REG_W-1:0] reg1,
    input logic [REG_W-1:0] reg2,
    input logic [CNT_W-1:0] data_bits,
    input logic [1:0]       chan_mode,
    input logic             multidrop_en
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!ptr_second && reg1 == '0 && reg2 == '0));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_second && acc_en && !ptr_rst) |=> ptr_second);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_second && !ptr_rst) |=> ptr_second);

    p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> !ptr_second);

    p_wr_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_second && acc_en && acc_wr) |=> (reg2 == $past(wdata)) && $stable(reg1));

    p_wr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_second && acc_en && acc_wr) |=> (reg1 == $past(wdata)) && $stable(reg2));

    p_bits_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_bits >= 4'd5 && data_bits <= 4'd8));

    p_mode_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_second && acc_en && acc_wr) |=> chan_mode == $past(wdata[7:6]));

    p_mdrop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg1[4:3] == 2'b11) |-> multidrop_en);
endmodule

bind mode_regs mode_regs_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en       (acc_en),
    .acc_wr       (acc_wr),
    .wdata        (wdata),
    .ptr_rst      (ptr_rst),
    .ptr_second   (ptr_second),
    .reg1         (reg1_q),
    .reg2         (reg2_q),
    .data_bits    (data_bits),
    .chan_mode    (chan_mode),
    .multidrop_en (multidrop_en)
);

// File: tb/test_mode_regs.sv
module test_mode_regs;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_en, acc_wr, ptr_rst;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       rx_rts_ctl, irq_src_full, err_block, par_type, multidrop_en, ad_polarity;
    logic [1:0] par_mode, chan_mode;
    logic [3:0] data_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m1, m2;
    bit         mptr;

    always #5 clk = ~clk;

    mode_regs i_mode_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .wdata(wdata), .rdata(rdata), .ptr_rst(ptr_rst),
        .rx_rts_ctl(rx_rts_ctl), .irq_src_full(irq_src_full), .err_block(err_block),
        .par_mode(par_mode), .par_type(par_type), .multidrop_en(multidrop_en),
        .ad_polarity(ad_polarity), .data_bits(data_bits), .chan_mode(chan_mode)
    );

    function automatic logic [3:0] exp_bits(input logic [1:0] c);
        return 4'd5 + {2'b00, c};
    endfunction

    function automatic logic exp_mdrop(input logic [1:0] c);
        return c == 2'b11;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs();
        check("R6 rts",   {31'd0, rx_rts_ctl},   {31'd0, m1[7]});
        check("R6 irq",   {31'd0, irq_src_full}, {31'd0, m1[6]});
        check("R6 err",   {31'd0, err_block},    {31'd0, m1[5]});
        check("R6 pmode", {30'd0, par_mode},     {30'd0, m1[4:3]});
        check("R6 ptype", {31'd0, par_type},     {31'd0, m1[2]});
        check("R7 bits",  {28'd0, data_bits},    {28'd0, exp_bits(m1[1:0])});
        check("R8 mode",  {30'd0, chan_mode},    {30'd0, m2[7:6]});
        check("R9 mdrop", {31'd0, multidrop_en}, {31'd0, exp_mdrop(m1[4:3])});
        check("R9 adpol", {31'd0, ad_polarity},  {31'd0, exp_mdrop(m1[4:3]) & m1[2]});
    endtask

    // one cycle: drive at negedge, check read data, update model at edge
    task automatic step(input logic en, input logic wr, input logic [7:0] d, input logic pr,
                        input string tag);
        @(negedge clk);
        acc_en = en; acc_wr = wr; wdata = d; ptr_rst = pr;
        #1;
        if (en && !wr) check({tag, " R10 rdata"}, {24'd0, rdata}, {24'd0, mptr ? m2 : m1});
        else           check("R10 idle rdata", {24'd0, rdata}, 32'd0);
        @(posedge clk);
        if (en && wr) begin
            if (mptr) m2 = d; else m1 = d;
        end
        if (pr)      mptr = 1'b0;
        else if (en) mptr = 1'b1;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; ptr_rst = 1'b0;
        check_outs();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; wdata = '0; ptr_rst = 1'b0;
        m1 = '0; m2 = '0; mptr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        check("R1 bits", {28'd0, data_bits}, 32'd5);
        check("R1 mode", {30'd0, chan_mode}, 32'd0);
        check_outs();
        step(1'b1, 1'b0, 8'h00, 1'b0, "R1");   // read reg1 = 0, advances (R2)
        step(1'b1, 1'b0, 8'h00, 1'b0, "R2");   // read now sees reg2 = 0
        // R4 rewind then R2 write lands in reg1
        step(1'b0, 1'b0, 8'h00, 1'b1, "R4");
        step(1'b1, 1'b1, 8'hA5, 1'b0, "R2");
        step(1'b1, 1'b1, 8'h40, 1'b0, "R3");   // reg2, echo mode
        step(1'b1, 1'b0, 8'h00, 1'b0, "R3");   // read reg2 again
        // R5: write + rewind while at reg2 -> lands in reg2
        step(1'b1, 1'b1, 8'hC0, 1'b1, "R5");
        step(1'b1, 1'b0, 8'h00, 1'b0, "R5");   // read reg1, unchanged A5
        step(1'b1, 1'b0, 8'h00, 1'b0, "R5");   // read reg2 = C0
        // R5: write + rewind while at reg1 -> lands in reg1, stays at reg1
        step(1'b0, 1'b0, 8'h00, 1'b1, "R4");
        step(1'b1, 1'b1, 8'h1B, 1'b1, "R5");
        step(1'b1, 1'b0, 8'h00, 1'b0, "R5");
        // R7/R9 sweep of all length and parity codes with both type bits
        for (int c = 0; c < 16; c++) begin
            step(1'b0, 1'b0, 8'h00, 1'b1, "R4");
            step(1'b1, 1'b1, {3'b000, c[3:2], c[0], c[1:0]}, 1'b0, "R7");
        end
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2], r[15:8], (r[7:4] == 4'h0), "RND");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule